// File: doc/BRIEF.md
# Dual-Target Serial Load Register with Status Readback

This block is the serial front end of a multi-channel PWM LED driver. A host shifts a 288-bit word into it one bit at a time and then raises a latch strobe. The level of the strobe at the most recent shift edge picks where the word goes:

- **Strobe low:** the whole word goes to the grayscale latch.
- **Strobe high:** the word goes to the configuration store. The low 199 bits go to the configuration latch. Bits 199 to 215 go to the upper field of the configuration shift register.

Every transfer then replaces the shift register contents with a status word. The host clocks the status word out on the serial output while it shifts in the next frame.

The status word is built from several sources:

- the configuration contents that are in force after the transfer;
- a block of reserved zero bits;
- a thermal flag;
- per-channel short flags and open flags.

A small capture unit takes the open and short flags once per display period. Capture happens on the 33rd grayscale clock tick after the blank signal rises. The detectors that drive these inputs sit outside the block.

All events are clock enables in one clock domain. A shift edge is a cycle with `shift_en` high. A grayscale clock edge is a cycle with `gs_tick` high.

Top module: `srl_dual_load`

## Requirements
- R1: On a cycle with `shift_en` high and no transfer, bit 0 of the shift register takes `ser_in` and every other bit k takes the old bit k-1. `ser_out` always shows bit 287.
- R2: If the strobe was low at the most recent shift edge, a transfer copies all 288 bits into `gs_latch`. `cfg_latch` and `cfg_user` do not change.
- R3: If the strobe was high at the most recent shift edge, a transfer copies shift bits 198..0 into `cfg_latch` and bits 215..199 into `cfg_user`. `gs_latch` does not change.
- R4: The strobe level is sampled at every shift edge, and the last sample picks the target. A strobe rise with no shift in the same cycle transfers at that clock edge. A strobe rise in a shift cycle counts as high at that edge; its transfer takes place on the first later cycle with no shift. A second rise with no shift between reuses the old target.
- R5: In the grayscale word, channel c of colour group g (red=0, green=1, blue=2) owns bits (3c+g)*12+11 down to (3c+g)*12. Red channel 0 sits in bits 11..0 and blue channel 7 in bits 287..276.
- R6: On the clock edge of a transfer, the shift register loads a status word with these fields:
  - bits 215..0: {`cfg_user`, `cfg_latch`} as they stand after that transfer;
  - bits 238..216: zero;
  - bit 239: `thermal_hot` in the transfer cycle;
  - bits 263..240: the held short flags;
  - bits 287..264: the held open flags.

  Within each flag field, bit index 8g+c belongs to group g, channel c.
- R7: The held open/short flags take `open_det`/`short_det` on the 33rd `gs_tick` after `blank` rises. Ticks in the cycle of the rise do not count. A fall of `blank` cancels a pending capture. At all other times the flags hold.
- R8: After reset, every latch, the shift register, the held flags and `ser_out` are zero, and the stored target is grayscale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Serial shift edge (one per cycle high) |
| ser_in | input | 1 | Serial data in |
| strobe | input | 1 | Latch strobe level |
| blank | input | 1 | Display enable level; rise starts a flag capture window |
| gs_tick | input | 1 | Grayscale clock edge |
| open_det | input | 24 | Open-LED detector outputs, index 8g+c |
| short_det | input | 24 | Shorted-LED detector outputs, index 8g+c |
| thermal_hot | input | 1 | Over-temperature indication |
| ser_out | output | 1 | Serial data out (shift register MSB) |
| gs_latch | output | 288 | Grayscale latch |
| cfg_latch | output | 199 | Configuration latch |
| cfg_user | output | 17 | Upper field of configuration shift register |

## Verification
The most important corner case is a strobe that rises together with the final shift edge. A design that sampled the target one edge late would send a configuration frame to the grayscale latch. A design that transferred in that same cycle would copy a word that is one bit short.

The status reload is checked right after a configuration write. A design that built the status word from the old configuration would read back stale bits 0..215. Two strobe rises with no shift between them show whether the target choice is kept and whether the status word itself lands in the grayscale latch.

The flag window is probed at 32, 33 and 40+ ticks. An off-by-one counter, or a capture that keeps refreshing, shows up as wrong flags in the readback.

// File: rtl/srl_pkg.sv
package srl_pkg;

  typedef enum logic {
    TGT_GRAY = 1'b0,
    TGT_CFG  = 1'b1
  } target_e;

endpackage

// File: rtl/srl_target_sel.sv
module srl_target_sel
  import srl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    shift_en,
  input  logic    strobe,
  output logic    xfer_fire,
  output target_e target
);

  logic strobe_q;
  logic pend_q;
  logic strobe_rise;

  assign strobe_rise = strobe & ~strobe_q;
  // A rise seen in a shift cycle waits for the first shift-free cycle
  assign xfer_fire   = (strobe_rise | pend_q) & ~shift_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      pend_q   <= 1'b0;
      target   <= TGT_GRAY;
    end else begin
      strobe_q <= strobe;
      if (shift_en) target <= strobe ? TGT_CFG : TGT_GRAY;
      if (xfer_fire)                  pend_q <= 1'b0;
      else if (strobe_rise && shift_en) pend_q <= 1'b1;
    end
  end

  // R4: selection follows the strobe level at the latest shift edge
  assert_sel_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (target == ($past(strobe) ? TGT_CFG : TGT_GRAY)));

  // R4: never transfer in a cycle that shifts
  assert_no_fire_on_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> !xfer_fire);

  // R4: a rise coinciding with a shift is not lost
  assert_deferred_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rise && shift_en) |=> (pend_q || xfer_fire));

endmodule

// File: rtl/srl_flag_capture.sv
module srl_flag_capture #(
  parameter int NFLAG    = 24,
  parameter int CAP_TICK = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank,
  input  logic             gs_tick,
  input  logic [NFLAG-1:0] open_in,
  input  logic [NFLAG-1:0] short_in,
  output logic [NFLAG-1:0] open_q,
  output logic [NFLAG-1:0] short_q,
  output logic             capture
);

  localparam int CW = $clog2(CAP_TICK + 1);

  logic          blank_q;
  logic          armed_q;
  logic [CW-1:0] tick_cnt;
  logic          blank_rise;
  logic          last_tick;

  assign blank_rise = blank & ~blank_q;
  assign last_tick  = (tick_cnt == CW'(CAP_TICK - 1));
  assign capture    = armed_q & blank & ~blank_rise & gs_tick & last_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank_q  <= 1'b0;
      armed_q  <= 1'b0;
      tick_cnt <= '0;
      open_q   <= '0;
      short_q  <= '0;
    end else begin
      blank_q <= blank;
      if (blank_rise) begin
        armed_q  <= 1'b1;
        tick_cnt <= '0;
      end else if (!blank) begin
        armed_q  <= 1'b0;
      end else if (armed_q && gs_tick) begin
        if (last_tick) armed_q <= 1'b0;
        else           tick_cnt <= tick_cnt + 1'b1;
      end
      if (capture) begin
        open_q  <= open_in;
        short_q <= short_in;
      end
    end
  end

  // R7: held flags move only on a capture event
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(open_q) && $stable(short_q)));

  // R7: capture requires blank to be high and a grayscale tick
  assert_capture_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (blank && gs_tick));

  // R7: one capture per window
  assert_single_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);

endmodule

// File: rtl/srl_shift_core.sv
module srl_shift_core #(
  parameter int W = 288
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         ser_in,
  input  logic         load_en,
  input  logic [W-1:0] load_word,
  output logic [W-1:0] sr
);

  always_ff @(posedge clk) begin
    if (!rst_n)        sr <= '0;
    else if (load_en)  sr <= load_word;
    else if (shift_en) sr <= {sr[W-2:0], ser_in};
  end

  // R1: one-position move toward the MSB with the new bit at bit 0
  assert_shift_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> (sr == {$past(sr[W-2:0]), $past(ser_in)}));

  // R6: a load takes the presented word
  assert_load_takes_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (sr == $past(load_word)));

endmodule

// File: rtl/srl_dual_load.sv
module srl_dual_load
  import srl_pkg::*;
#(
  parameter int GROUPS       = 3,
  parameter int CH_PER_GROUP = 8,
  parameter int GS_BITS      = 12,
  parameter int CFG_LATCH_W  = 199,
  parameter int CFG_W        = 216,
  parameter int CAP_TICK     = 33
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       shift_en,
  input  logic                                       ser_in,
  input  logic                                       strobe,
  input  logic                                       blank,
  input  logic                                       gs_tick,
  input  logic [GROUPS*CH_PER_GROUP-1:0]             open_det,
  input  logic [GROUPS*CH_PER_GROUP-1:0]             short_det,
  input  logic                                       thermal_hot,
  output logic                                       ser_out,
  output logic [GROUPS*CH_PER_GROUP*GS_BITS-1:0]     gs_latch,
  output logic [CFG_LATCH_W-1:0]                     cfg_latch,
  output logic [CFG_W-CFG_LATCH_W-1:0]               cfg_user
);

  localparam int NCH       = GROUPS * CH_PER_GROUP;
  localparam int SR_W      = NCH * GS_BITS;
  localparam int USER_W    = CFG_W - CFG_LATCH_W;
  localparam int THERM_BIT = SR_W - 2 * NCH - 1;
  localparam int RSV_W     = THERM_BIT - CFG_W;

  // Status word: {open, short, thermal, reserved zeros, configuration}
  function automatic logic [SR_W-1:0] pack_status(
    input logic [CFG_W-1:0] cfg,
    input logic             hot,
    input logic [NCH-1:0]   shorts,
    input logic [NCH-1:0]   opens
  );
    return {opens, shorts, hot, {RSV_W{1'b0}}, cfg};
  endfunction

  logic             xfer_fire;
  target_e          target;
  logic [SR_W-1:0]  sr;
  logic [NCH-1:0]   open_q;
  logic [NCH-1:0]   short_q;
  logic             flag_capture;
  logic [CFG_W-1:0] cfg_after;
  logic [SR_W-1:0]  status_word;

  srl_target_sel u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .strobe    (strobe),
    .xfer_fire (xfer_fire),
    .target    (target)
  );

  srl_flag_capture #(
    .NFLAG    (NCH),
    .CAP_TICK (CAP_TICK)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .blank    (blank),
    .gs_tick  (gs_tick),
    .open_in  (open_det),
    .short_in (short_det),
    .open_q   (open_q),
    .short_q  (short_q),
    .capture  (flag_capture)
  );

  // Configuration contents that are in force once this transfer completes
  assign cfg_after   = (target == TGT_CFG) ? sr[CFG_W-1:0] : {cfg_user, cfg_latch};
  assign status_word = pack_status(cfg_after, thermal_hot, short_q, open_q);

  srl_shift_core #(.W(SR_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .ser_in    (ser_in),
    .load_en   (xfer_fire),
    .load_word (status_word),
    .sr        (sr)
  );

  assign ser_out = sr[SR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gs_latch  <= '0;
      cfg_latch <= '0;
      cfg_user  <= '0;
    end else if (xfer_fire) begin
      if (target == TGT_GRAY) begin
        gs_latch <= sr;
      end else begin
        cfg_latch <= sr[CFG_LATCH_W-1:0];
        cfg_user  <= sr[CFG_W-1:CFG_LATCH_W];
      end
    end
  end

  // R2: grayscale transfer copies the full word and leaves configuration alone
  assert_gray_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && target == TGT_GRAY) |=>
      (gs_latch == $past(sr) && $stable(cfg_latch) && $stable(cfg_user)));

  // R3: configuration transfer splits the low field and leaves grayscale alone
  assert_cfg_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && target == TGT_CFG) |=>
      (cfg_latch == $past(sr[CFG_LATCH_W-1:0]) &&
       cfg_user  == $past(sr[CFG_W-1:CFG_LATCH_W]) && $stable(gs_latch)));

  // R6: after a transfer the reserved span reads zero and the config field matches the stores
  assert_status_layout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire |=> (sr[THERM_BIT-1:CFG_W] == '0 &&
                   sr[CFG_W-1:0] == {cfg_user, cfg_latch}));

  // R6: flag fields carry the held detector flags
  assert_status_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire |=> (sr[SR_W-1:SR_W-NCH] == $past(open_q) &&
                   sr[SR_W-NCH-1:THERM_BIT+1] == $past(short_q) &&
                   sr[THERM_BIT] == $past(thermal_hot)));

  // R8: latches idle unless a transfer fires
  assert_latch_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_fire |=> ($stable(gs_latch) && $stable(cfg_latch) && $stable(cfg_user)));

endmodule

// File: tb/tb_srl_dual_load.sv
module tb_srl_dual_load;

  localparam int CLK_PERIOD = 10;
  localparam int SR_W  = 288;
  localparam int NCH   = 24;
  localparam int CFG_W = 216;
  localparam int CL_W  = 199;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            shift_en = 1'b0;
  logic            ser_in = 1'b0;
  logic            strobe = 1'b0;
  logic            blank = 1'b0;
  logic            gs_tick = 1'b0;
  logic [NCH-1:0]  open_det = '0;
  logic [NCH-1:0]  short_det = '0;
  logic            thermal_hot = 1'b0;
  logic            ser_out;
  logic [SR_W-1:0] gs_latch;
  logic [CL_W-1:0] cfg_latch;
  logic [CFG_W-CL_W-1:0] cfg_user;

  int n_checks = 0;
  int n_fail   = 0;
  logic [CFG_W-1:0] cfg_model = '0;

  srl_dual_load dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
    .strobe(strobe), .blank(blank), .gs_tick(gs_tick),
    .open_det(open_det), .short_det(short_det), .thermal_hot(thermal_hot),
    .ser_out(ser_out), .gs_latch(gs_latch), .cfg_latch(cfg_latch),
    .cfg_user(cfg_user)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [SR_W-1:0] act,
                     input logic [SR_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected status word per R6, assembled field by field
  function automatic logic [SR_W-1:0] exp_status(input logic [CFG_W-1:0] cfg,
      input logic hot, input logic [NCH-1:0] sh, input logic [NCH-1:0] op);
    logic [SR_W-1:0] w;
    w = '0;
    for (int i = 0; i < CFG_W; i++) w[i] = cfg[i];
    w[239] = hot;
    for (int i = 0; i < NCH; i++) begin
      w[240 + i] = sh[i];
      w[264 + i] = op[i];
    end
    return w;
  endfunction

  function automatic int gs_lsb(input int grp, input int ch);
    return (ch * 3 + grp) * 12;
  endfunction

  task automatic do_cycle(input logic sh, input logic si, input logic st);
    @(negedge clk);
    shift_en = sh; ser_in = si; strobe = st;
    @(posedge clk); #1;
  endtask

  task automatic shift_word(input logic [SR_W-1:0] d, input logic last_st);
    for (int i = SR_W - 1; i >= 0; i--) do_cycle(1'b1, d[i], (i == 0) ? last_st : 1'b0);
  endtask

  task automatic strobe_pulse();
    do_cycle(1'b0, 1'b0, 1'b1);
    do_cycle(1'b0, 1'b0, 1'b0);
  endtask

  task automatic readback(output logic [SR_W-1:0] rb);
    for (int k = 0; k < SR_W; k++) begin
      rb[SR_W-1-k] = ser_out;
      do_cycle(1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic tick();
    @(negedge clk); gs_tick = 1'b1;
    @(negedge clk); gs_tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 gs_latch", gs_latch, '0);
    chk("R8 cfg_latch", SR_W'(cfg_latch), '0);
    chk("R8 cfg_user", SR_W'(cfg_user), '0);
    chk("R8 ser_out", SR_W'(ser_out), '0);
  endtask

  task automatic t_shift_path();
    logic [SR_W-1:0] p, rb;
    p = {9{32'hC3A5_1E77}};
    shift_word(p, 1'b0);
    chk("R1 ser_out is msb", SR_W'(ser_out), SR_W'(p[SR_W-1]));
    readback(rb);
    chk("R1 raw shift readback", rb, p);
    chk("R1 no latch without strobe", gs_latch, '0);
  endtask

  task automatic t_gray_write();
    logic [SR_W-1:0] d, rb;
    d = '0;
    for (int g = 0; g < 3; g++)
      for (int c = 0; c < 8; c++)
        d[gs_lsb(g, c) +: 12] = 12'(16'h100 * g + 16'h10 * c + 16'h5);
    d[11:0] = 12'hABC; d[287:276] = 12'h5E1;
    shift_word(d, 1'b0);
    chk("R2 not yet latched", gs_latch, '0);
    do_cycle(1'b0, 1'b0, 1'b1);
    chk("R2 gray copy", gs_latch, d);
    chk("R2 cfg untouched", SR_W'({cfg_user, cfg_latch}), SR_W'(cfg_model));
    chk("R5 red ch0 field", SR_W'(gs_latch[11:0]), SR_W'(12'hABC));
    chk("R5 blue ch7 field", SR_W'(gs_latch[287:276]), SR_W'(12'h5E1));
    chk("R5 green ch3 field", SR_W'(gs_latch[gs_lsb(1, 3) +: 12]), SR_W'(12'h135));
    do_cycle(1'b0, 1'b0, 1'b0);
    readback(rb);
    chk("R6 status after gray write", rb, exp_status(cfg_model, 1'b0, '0, '0));
  endtask

  task automatic t_cfg_write();
    logic [SR_W-1:0] c, rb, gs_before;
    c = {9{32'h9E37_79B9}} ^ {36{8'h5A}};
    gs_before = gs_latch;
    thermal_hot = 1'b1;
    shift_word(c, 1'b1);
    chk("R4 rise on last shift defers transfer", SR_W'(cfg_latch), '0);
    do_cycle(1'b0, 1'b0, 1'b1);
    cfg_model = c[CFG_W-1:0];
    chk("R3 cfg latch low field", SR_W'(cfg_latch), SR_W'(c[CL_W-1:0]));
    chk("R3 cfg user field", SR_W'(cfg_user), SR_W'(c[CFG_W-1:CL_W]));
    chk("R3 gray untouched", gs_latch, gs_before);
    do_cycle(1'b0, 1'b0, 1'b0);
    thermal_hot = 1'b0;
    readback(rb);
    chk("R6 status shows new cfg and thermal", rb, exp_status(cfg_model, 1'b1, '0, '0));
  endtask

  task automatic t_reuse_target();
    logic [SR_W-1:0] d, st;
    d = {12{24'h6B2D17}};
    shift_word(d, 1'b0);
    strobe_pulse();
    chk("R4 low at last shift picks gray", gs_latch, d);
    st = exp_status(cfg_model, 1'b0, '0, '0);
    strobe_pulse();
    chk("R4 second rise reuses gray target", gs_latch, st);
    // strobe raised on the first shift and held: config target after shifting
    d = {9{32'h0F1E_2D3C}};
    for (int i = SR_W - 1; i >= 0; i--) do_cycle(1'b1, d[i], 1'b1);
    chk("R4 no transfer while shifting", SR_W'(cfg_latch), SR_W'(cfg_model[CL_W-1:0]));
    do_cycle(1'b0, 1'b0, 1'b1);
    cfg_model = d[CFG_W-1:0];
    chk("R4 held strobe selects cfg", SR_W'({cfg_user, cfg_latch}), SR_W'(cfg_model));
    do_cycle(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_flags();
    logic [SR_W-1:0] rb;
    logic [NCH-1:0] a_op, a_sh;
    a_op = 24'h81_42_18; a_sh = 24'h03_C0_5A;
    open_det = a_op; short_det = a_sh;
    @(negedge clk); blank = 1'b1;
    @(negedge clk);
    repeat (32) tick();
    strobe_pulse();
    readback(rb);
    chk("R7 no capture at tick 32", rb, exp_status(cfg_model, 1'b0, '0, '0));
    tick();
    open_det = 24'hFFFFFF; short_det = 24'h123456;
    strobe_pulse();
    readback(rb);
    chk("R7 capture at tick 33", rb, exp_status(cfg_model, 1'b0, a_sh, a_op));
    repeat (10) tick();
    strobe_pulse();
    readback(rb);
    chk("R7 flags held after window", rb, exp_status(cfg_model, 1'b0, a_sh, a_op));
    // blank falls mid-window: pending capture cancelled
    @(negedge clk); blank = 1'b0;
    @(negedge clk); blank = 1'b1;
    @(negedge clk);
    repeat (20) tick();
    @(negedge clk); blank = 1'b0;
    @(negedge clk); blank = 1'b1;
    @(negedge clk);
    open_det = 24'h00_00_01; short_det = 24'h80_00_00;
    repeat (20) tick();
    strobe_pulse();
    readback(rb);
    chk("R7 blank fall restarts count", rb, exp_status(cfg_model, 1'b0, a_sh, a_op));
    repeat (13) tick();
    strobe_pulse();
    readback(rb);
    chk("R6 flag packing red lsb blue msb", rb,
        exp_status(cfg_model, 1'b0, 24'h80_00_00, 24'h00_00_01));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_shift_path();
    t_gray_write();
    t_cfg_write();
    t_reuse_target();
    t_flags();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule